// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the fetch address register of a simple single-issue processor and picks the address of the next instruction on every rising clock edge. It takes the instruction word that is currently being fetched, a branch request, the equality result from the register compare (the zero flag) and a jump request. From these it selects one of three sources: the sequential address, a PC-relative branch target, or a pseudo-absolute jump target. The branch target is the word offset from the low half of the instruction, sign-extended and scaled to bytes, added to the sequential address. The jump target keeps the top four bits of the sequential address and fills the rest from the 26-bit target field of the instruction, scaled to bytes.

The current PC, the sequential address and the branch target are all outputs, so that neighbouring logic can use them without computing them again. The register has no load enable and changes on every edge. All address arithmetic wraps modulo 2^32 and nothing flags an overflow. A synchronous active-low reset returns the PC to zero.

Top module: `npc_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `pc` becomes 0 after that edge, regardless of `jump`, `branch` and `zero`.
- R2: `pc_plus4` always equals `pc + 4` modulo 2^32, so `pc` = 0xFFFFFFFC gives `pc_plus4` = 0.
- R3: `br_target` equals `pc_plus4` plus the 16-bit field `insn[15:0]`, sign-extended from bit 15 and shifted left by 2, modulo 2^32.
- R4: With `jump` = 0 and `branch` = 0, the PC after an edge is the `pc_plus4` value from before it.
- R5: With `jump` = 0, `branch` = 1 and `zero` = 1, the PC after an edge is the `br_target` value from before it.
- R6: A branch is not taken unless both `branch` and `zero` are 1: `branch` = 1 with `zero` = 0, or `zero` = 1 with `branch` = 0, give the sequential address.
- R7: With `jump` = 1, the next PC has bits 27:0 equal to `{insn[25:0], 2'b00}` and bits 31:28 taken from `pc_plus4` (not from `pc`).
- R8: When `jump` = 1 and a taken branch (`branch` = 1, `zero` = 1) coincide, the jump target is used.
- R9: After reset, `pc[1:0]` stays 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC is loaded on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| insn | input | 32 | Instruction word being fetched at the current PC |
| branch | input | 1 | Conditional branch request |
| zero | input | 1 | Equality result of the register compare |
| jump | input | 1 | Unconditional jump request |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential address, PC + 4 |
| br_target | output | 32 | PC-relative branch target |

## Verification
The PC is the only state, so a fault in selection, priority or target arithmetic shows up on `pc` at the first edge after the stimulus that uses the faulty path. After one edge a wrong upper-bit source for the jump, an inverted branch condition or a lost carry is visible, and each later sequential step keeps the error. The stimulus therefore crosses the 4-bit region boundary and the 32-bit wrap, and uses offsets at both ends of the signed range, so that each of these faults changes an observed address.

// File: rtl/npc_pkg.sv
// Package: shared types for the next program counter unit.
// Assumes: nothing beyond IEEE 1800-2017.
package npc_pkg;

    // Source chosen for the next fetch address.
    typedef enum logic [1:0] {
        NPC_SEQ  = 2'd0,
        NPC_BR   = 2'd1,
        NPC_JMP  = 2'd2
    } npc_src_e;

endpackage

// File: rtl/npc_pc_reg.sv
// Module: npc_pc_reg
// Holds the program counter. Loads the next address on every rising
// edge (there is no enable); a synchronous active-low reset clears it.
// Assumes: rst_n is synchronous to clk.
module npc_pc_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    // PC register: clear on reset, otherwise take the next address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else begin
            cur_addr <= next_addr;
        end
    end

endmodule

// File: rtl/npc_target_gen.sv
// Module: npc_target_gen
// Computes the three candidate addresses: sequential (PC + STEP),
// PC-relative branch target and region-relative jump target.
// Assumes: STEP is a power of two; all sums wrap modulo 2^ADDR_W.
module npc_target_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int TGT_W  = 26,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [TGT_W-1:0]  jmp_field,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] br_addr,
    output logic [ADDR_W-1:0] jmp_addr
);

    localparam int SHIFT  = $clog2(STEP);
    localparam int EXT_W  = ADDR_W - OFF_W - SHIFT;
    localparam int LOW_W  = TGT_W + SHIFT;
    localparam int HIGH_W = ADDR_W - LOW_W;

    logic [ADDR_W-1:0] offset_bytes;

    // Sequential address: step by one instruction.
    always_comb begin
        seq_addr = cur_addr + ADDR_W'(STEP);
    end

    // Sign-extend the word offset and scale it to bytes.
    always_comb begin
        offset_bytes = {{EXT_W{br_offset[OFF_W-1]}}, br_offset, {SHIFT{1'b0}}};
    end

    // Branch target relative to the sequential address.
    always_comb begin
        br_addr = seq_addr + offset_bytes;
    end

    // Jump target: keep the region bits of the sequential address.
    generate
        if (HIGH_W > 0) begin : g_region
            always_comb begin
                jmp_addr = {seq_addr[ADDR_W-1:LOW_W], jmp_field, {SHIFT{1'b0}}};
            end
        end else begin : g_flat
            always_comb begin
                jmp_addr = ADDR_W'({jmp_field, {SHIFT{1'b0}}});
            end
        end
    endgenerate

endmodule

// File: rtl/npc_select.sv
// Module: npc_select
// Decides the source of the next address and drives the multiplexer.
// Jump wins over a taken branch; a branch is taken only when the
// compare result is also set.
// Assumes: control inputs are settled before the clock edge.
module npc_select #(
    parameter int ADDR_W = 32
) (
    input  logic              branch,
    input  logic              zero,
    input  logic              jump,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    output logic [ADDR_W-1:0] next_addr
);

    import npc_pkg::*;

    npc_src_e src;

    // Priority decode of the address source.
    always_comb begin
        if (jump) begin
            src = NPC_JMP;
        end else if (branch && zero) begin
            src = NPC_BR;
        end else begin
            src = NPC_SEQ;
        end
    end

    // Next-address multiplexer.
    always_comb begin
        unique case (src)
            NPC_JMP: next_addr = jmp_addr;
            NPC_BR:  next_addr = br_addr;
            default: next_addr = seq_addr;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit
// Top of the next program counter unit: PC register, candidate
// address generation and source selection.
// Assumes: fixed 32-bit instructions with the offset in the low
// field and the jump target in the low TGT_W bits.
module npc_unit #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32,
    parameter int OFF_W  = 16,
    parameter int TGT_W  = 26,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn,
    input  logic              branch,
    input  logic              zero,
    input  logic              jump,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_plus4,
    output logic [ADDR_W-1:0] br_target
);

    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              unused_opcode_bits;

    // Opcode bits are decoded elsewhere.
    always_comb begin
        unused_opcode_bits = ^insn[INSN_W-1:TGT_W];
    end

    npc_pc_reg #(
        .ADDR_W (ADDR_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_addr (next_addr),
        .cur_addr  (pc)
    );

    npc_target_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .TGT_W  (TGT_W),
        .STEP   (STEP)
    ) u_tgt (
        .cur_addr  (pc),
        .br_offset (insn[OFF_W-1:0]),
        .jmp_field (insn[TGT_W-1:0]),
        .seq_addr  (pc_plus4),
        .br_addr   (br_target),
        .jmp_addr  (jmp_addr)
    );

    npc_select #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .branch    (branch),
        .zero      (zero),
        .jump      (jump),
        .seq_addr  (pc_plus4),
        .br_addr   (br_target),
        .jmp_addr  (jmp_addr),
        .next_addr (next_addr)
    );

endmodule

// File: rtl/npc_unit_chk.sv
// Module: npc_unit_chk
// Temporal checks on the ports of npc_unit, attached by bind.
// Assumes: default parameter values (32-bit addresses, 26-bit target).
module npc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] insn,
    input logic        branch,
    input logic        zero,
    input logic        jump,
    input logic [31:0] pc,
    input logic [31:0] pc_plus4,
    input logic [31:0] br_target
);

    // R1: reset at an edge leaves the PC at zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> pc == 32'h0);

    // R4: no control request gives the sequential address.
    assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump && !branch) |=> pc == $past(pc_plus4));

    // R5: taken branch loads the branch target.
    assert_br_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump && branch && zero) |=> pc == $past(br_target));

    // R6: branch without a set compare result falls through.
    assert_br_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump && branch && !zero) |=> pc == $past(pc_plus4));

    // R7: jump fills the low bits and keeps the region of PC + 4.
    assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> (pc[27:0] == {$past(insn[25:0]), 2'b00})
              && (pc[31:28] == $past(pc_plus4[31:28])));

    // R8: jump beats a coincident taken branch.
    assert_jump_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (jump && branch && zero) |=> pc[27:0] == {$past(insn[25:0]), 2'b00});

    // R9: PC stays word aligned.
    assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc[1:0] == 2'b00);

endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn      (insn),
    .branch    (branch),
    .zero      (zero),
    .jump      (jump),
    .pc        (pc),
    .pc_plus4  (pc_plus4),
    .br_target (br_target)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] insn;
    logic        branch;
    logic        zero;
    logic        jump;
    logic [31:0] pc;
    logic [31:0] pc_plus4;
    logic [31:0] br_target;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    npc_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn      (insn),
        .branch    (branch),
        .zero      (zero),
        .jump      (jump),
        .pc        (pc),
        .pc_plus4  (pc_plus4),
        .br_target (br_target)
    );

    typedef struct packed {
        logic [31:0] insn;
        logic        br;
        logic        z;
        logic        j;
        logic [31:0] cur;
        logic [31:0] tgt;
        logic [31:0] nxt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        // R6: zero set without branch falls through
        '{32'h0000_0003, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0010, 32'h0000_0004, 8'd6},
        // R5: forward taken branch
        '{32'h0000_0010, 1'b1, 1'b1, 1'b0, 32'h0000_0004, 32'h0000_0048, 32'h0000_0048, 8'd5},
        // R6: branch with zero clear falls through
        '{32'h0000_FFFF, 1'b1, 1'b0, 1'b0, 32'h0000_0048, 32'h0000_0048, 32'h0000_004C, 8'd6},
        // R5: offset -1 loops on itself
        '{32'h0000_FFFF, 1'b1, 1'b1, 1'b0, 32'h0000_004C, 32'h0000_004C, 32'h0000_004C, 8'd5},
        // R3: most negative offset wraps below zero
        '{32'h0000_8000, 1'b1, 1'b1, 1'b0, 32'h0000_004C, 32'hFFFE_0050, 32'hFFFE_0050, 8'd3},
        // R8: jump with a taken branch
        '{32'h0BFF_FFFF, 1'b1, 1'b1, 1'b1, 32'hFFFE_0050, 32'hFFFE_0050, 32'hFFFF_FFFC, 8'd8},
        // R2: sequential step wraps to zero
        '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0000, 8'd2},
        // R7: jump to the top of region 0
        '{32'h03FF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0FFF_FFFC, 8'd7},
        // R7: region bits come from PC + 4
        '{32'h0000_0001, 1'b0, 1'b0, 1'b1, 32'h0FFF_FFFC, 32'h1000_0004, 32'h1000_0004, 8'd7},
        // R3: most positive offset
        '{32'h0000_7FFF, 1'b1, 1'b1, 1'b0, 32'h1000_0004, 32'h1002_0004, 32'h1002_0004, 8'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        insn   = '0;
        branch = 1'b0;
        zero   = 1'b0;
        jump   = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", pc, 32'h0);
        chk("R2 pc_plus4 at reset", pc_plus4, 32'h4);
        rst_n = 1'b1;
        jump  = 1'b0;

        for (int i = 0; i < NV; i++) begin
            insn   = TBL[i].insn;
            branch = TBL[i].br;
            zero   = TBL[i].z;
            jump   = TBL[i].j;
            #1;
            chk($sformatf("R%0d vec %0d pc", TBL[i].req, i), pc, TBL[i].cur);
            chk($sformatf("R2 vec %0d pc_plus4", i), pc_plus4, TBL[i].cur + 32'd4);
            chk($sformatf("R3 vec %0d br_target", i), br_target, TBL[i].tgt);
            @(negedge clk);
            chk($sformatf("R%0d vec %0d next pc", TBL[i].req, i), pc, TBL[i].nxt);
        end

        // R4: three plain steps, no hold between edges
        insn = 32'h0000_1234; branch = 1'b0; zero = 1'b0; jump = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R4 sequential step", pc, 32'h1002_0004 + 32'(4 * k));
            chk("R9 alignment", {30'd0, pc[1:0]}, 32'h0);
        end

        // R1: reset is synchronous and beats a pending jump
        insn = 32'h0000_0040; jump = 1'b1; branch = 1'b1; zero = 1'b1;
        rst_n = 1'b0;
        #1;
        chk("R1 no change before edge", pc, 32'h1002_0010);
        @(negedge clk);
        chk("R1 reset beats jump", pc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 jump after reset", pc, 32'h0000_0100);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule